// File: doc/BRIEF.md
# Transmit Elastic Buffer with One-Shot Latency Setting

This block moves 8-bit timeslot bytes from a 32-channel system-side serial backplane into a 24-timeslot DS1 transmit frame. The two sides keep separate frame timing. A two-bank store of 24 bytes sits between them. Each system write of channel 1 starts a new system frame in the other bank. Each outgoing DS1 frame reads from the bank that took the most recent channel-1 write at the moment the frame starts.

The DS1 side is paced by a bit-period tick. One frame is 193 ticks: a framing bit position, then 24 timeslots of 8 bits. Software can write a delay value once. The next system write of channel 1 then starts a countdown. When the countdown ends, the internal DS1 frame boundary is moved so that this exact byte is read out after the programmed number of bit periods. The stored data is not touched. After the adjustment the frame counter runs free again, until the next delay write.

Top module: `tebDelaySetter`

## Requirements
- R1: After reset, `frameStart`, `adjDone` and `txByte` are 0 and the frame position is 0. With no delay programmed, the first `frameStart` follows the 193rd tick.
- R2: With no adjustment pending, `frameStart` is a one-cycle pulse that appears on the cycle after every 193rd tick.
- R3: Counting the frame-start tick as tick 0, the byte for timeslot k (1..24) appears on `txByte` after tick 8·(k−1) of the frame. It holds there until the next load.
- R4: System writes to channel 0 and to channels 25..31 are dropped. They change neither stored data nor the bank selection.
- R5: A write to channel 1 switches the write bank, and channels 2..24 then go to the same bank. A DS1 frame reads the bank that held the latest channel-1 write when the frame started, so a system frame written mid-frame shows up only in the next DS1 frame.
- R6: A register write with value D arms an adjustment with L = D mod 193, provided L ≠ 0. The most recent such write wins. The next channel-1 write starts the count. Exactly L ticks later, `frameStart` pulses and `txByte` carries that channel-1 byte.
- R7: An adjustment is used once. Later channel-1 writes leave the free-running boundary in place, and frames again repeat every 193 ticks from the adjusted boundary.
- R8: A register value whose remainder modulo 193 is 0 (0 or 193) is ignored. It neither arms nor cancels a pending adjustment.
- R9: Between the channel-1 write that starts the count and the adjusted boundary, `frameStart` stays low, even where the old frame would have ended inside that window.
- R10: `adjDone` pulses for one cycle, together with the `frameStart` pulse at the adjusted boundary, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysWrEn | input | 1 | System-side byte write strobe |
| sysChan | input | 5 | System-side channel index |
| sysData | input | 8 | System-side byte |
| dsTick | input | 1 | One-cycle pulse per DS1 bit period |
| regWrEn | input | 1 | Delay register write strobe |
| regData | input | 8 | Delay value in DS1 bit periods |
| txByte | output | 8 | Current outgoing DS1 timeslot byte |
| frameStart | output | 1 | One-cycle pulse at each DS1 frame boundary |
| adjDone | output | 1 | One-cycle pulse when the latency adjustment lands |

## Verification
The delay is swept over 1, 2, 5, 17, 100, 192, 200 and 255, starting from different free-running phases. This separates a correct modulo-193 countdown from an off-by-one count. Large delays, where the old boundary falls inside the wait, show whether the truncated frame's pulse is suppressed. Values 0 and 193 are written both while idle and while an adjustment is armed, and a pair of valid writes is issued back to back. These cases tell "ignored" apart from "cancelled" and show that the last valid write wins. Whole frames are written at varying phases, and writes to channels 0, 25 and 31 are mixed in. Every output byte is compared against a bank-accurate model, which exposes wrong bank switching, slot offsets or leaks from unused channels.

// File: rtl/tebPkg.sv
package tebPkg;
  localparam int SLOT_IDX_W = 5;

  typedef struct packed {
    logic                  load;
    logic                  newFrame;
    logic [SLOT_IDX_W-1:0] slot;
  } tebStrobe_t;
endpackage

// File: rtl/tebCtrl.sv
module tebCtrl
  import tebPkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int BYTE_W    = 8,
  parameter int CHAN_W    = 5,
  parameter int DLY_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickIn,
  input  logic              sysWrEn,
  input  logic [CHAN_W-1:0] sysChan,
  input  logic              regWrEn,
  input  logic [DLY_W-1:0]  regData,
  output tebStrobe_t        strobe,
  output logic              frameStart,
  output logic              adjDone
);
  localparam int FRAME_BITS = NUM_SLOTS * BYTE_W + 1;
  localparam int POS_W      = $clog2(FRAME_BITS + 1);
  localparam int LAST_LOAD  = (NUM_SLOTS - 1) * BYTE_W;

  logic [POS_W-1:0] bitPos, nextPos, effDly, pendL, cnt;
  logic             armed, adjusting, ch1Wr, adjHit, validDly;

  assign effDly   = POS_W'(32'(regData) % 32'(FRAME_BITS));
  assign validDly = regWrEn && (effDly != '0);
  assign ch1Wr    = sysWrEn && (sysChan == CHAN_W'(1));
  assign adjHit   = tickIn && adjusting && (cnt == POS_W'(1));

  always_comb begin
    if (adjHit) nextPos = '0;
    else if (bitPos == POS_W'(FRAME_BITS - 1)) nextPos = '0;
    else nextPos = bitPos + POS_W'(1);
  end

  always_comb begin
    strobe.newFrame = tickIn && (nextPos == '0);
    strobe.load     = tickIn && (32'(nextPos) % BYTE_W == 0) && (32'(nextPos) <= LAST_LOAD);
    strobe.slot     = SLOT_IDX_W'(32'(nextPos) / BYTE_W);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitPos     <= '0;
      armed      <= 1'b0;
      adjusting  <= 1'b0;
      pendL      <= '0;
      cnt        <= '0;
      frameStart <= 1'b0;
      adjDone    <= 1'b0;
    end else begin
      if (tickIn) bitPos <= nextPos;
      frameStart <= tickIn && (nextPos == '0) && (!adjusting || adjHit);
      adjDone    <= adjHit;
      if (validDly) begin
        armed     <= 1'b1;
        pendL     <= effDly;
        adjusting <= 1'b0;
      end else if (ch1Wr && armed) begin
        adjusting <= 1'b1;
        cnt       <= pendL;
        armed     <= 1'b0;
      end else if (tickIn && adjusting) begin
        if (cnt == POS_W'(1)) adjusting <= 1'b0;
        else cnt <= cnt - POS_W'(1);
      end
    end
  end

  // R2
  fs_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);
  // R2
  fs_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> $past(tickIn));
  // R10
  adj_with_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    adjDone |-> frameStart);
  // R6
  pos_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(bitPos) < FRAME_BITS);
  // R6
  count_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    adjusting |-> (cnt != '0));
endmodule

// File: rtl/tebData.sv
module tebData
  import tebPkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int BYTE_W    = 8,
  parameter int CHAN_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysWrEn,
  input  logic [CHAN_W-1:0] sysChan,
  input  logic [BYTE_W-1:0] sysData,
  input  tebStrobe_t        strobe,
  output logic [BYTE_W-1:0] txByte
);
  logic [BYTE_W-1:0] mem [2][NUM_SLOTS];
  logic              wrBank, rdBank, inRange, isCh1, tgtBank, selBank;
  logic [CHAN_W-1:0] wrIdx;

  assign inRange = sysWrEn && (sysChan != '0) && (32'(sysChan) <= NUM_SLOTS);
  assign isCh1   = (sysChan == CHAN_W'(1));
  assign tgtBank = isCh1 ? ~wrBank : wrBank;
  assign wrIdx   = sysChan - CHAN_W'(1);
  assign selBank = strobe.newFrame ? wrBank : rdBank;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrBank <= 1'b0;
      rdBank <= 1'b0;
      txByte <= '0;
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NUM_SLOTS; s++)
          mem[b][s] <= '0;
    end else begin
      if (inRange) begin
        mem[tgtBank][wrIdx] <= sysData;
        if (isCh1) wrBank <= ~wrBank;
      end
      if (strobe.load) begin
        txByte <= mem[selBank][strobe.slot];
        if (strobe.newFrame) rdBank <= wrBank;
      end
    end
  end

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(txByte));
  // R4
  unused_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysWrEn && !inRange) |=> $stable(wrBank));
endmodule

// File: rtl/tebDelaySetter.sv
module tebDelaySetter
  import tebPkg::*;
#(
  parameter int NUM_SLOTS = 24,
  parameter int BYTE_W    = 8,
  parameter int CHAN_W    = 5,
  parameter int DLY_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysWrEn,
  input  logic [CHAN_W-1:0] sysChan,
  input  logic [BYTE_W-1:0] sysData,
  input  logic              dsTick,
  input  logic              regWrEn,
  input  logic [DLY_W-1:0]  regData,
  output logic [BYTE_W-1:0] txByte,
  output logic              frameStart,
  output logic              adjDone
);
  tebStrobe_t strobe;

  tebCtrl #(.NUM_SLOTS(NUM_SLOTS), .BYTE_W(BYTE_W), .CHAN_W(CHAN_W), .DLY_W(DLY_W)) ctrl (
    .clk(clk), .rstN(rstN), .tickIn(dsTick), .sysWrEn(sysWrEn), .sysChan(sysChan),
    .regWrEn(regWrEn), .regData(regData), .strobe(strobe),
    .frameStart(frameStart), .adjDone(adjDone)
  );

  tebData #(.NUM_SLOTS(NUM_SLOTS), .BYTE_W(BYTE_W), .CHAN_W(CHAN_W)) data (
    .clk(clk), .rstN(rstN), .sysWrEn(sysWrEn), .sysChan(sysChan), .sysData(sysData),
    .strobe(strobe), .txByte(txByte)
  );
endmodule

// File: tb/tebDelaySetter_test.sv
module tebDelaySetter_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sysWrEn = 1'b0;
  logic [4:0] sysChan = '0;
  logic [7:0] sysData = '0;
  logic       dsTick = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regData = '0;
  logic [7:0] txByte;
  logic       frameStart, adjDone;

  tebDelaySetter uut (
    .clk(clk), .rstN(rstN), .sysWrEn(sysWrEn), .sysChan(sysChan), .sysData(sysData),
    .dsTick(dsTick), .regWrEn(regWrEn), .regData(regData),
    .txByte(txByte), .frameStart(frameStart), .adjDone(adjDone)
  );

  always #10 clk = ~clk;

  int nChk = 0, nBad = 0;
  bit done = 0;
  int mMem [2][24];
  int mPos = 0, mCnt = 0, mL = 0, mWr = 0, mRd = 0, expByte = 0;
  bit mAdj = 0, mArm = 0;
  int sinceMark = 0, firstFs = -1, adjCnt = 0, frameNo = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doTick();
    bit wasAdj, hit, expFs, expAdj;
    int np;
    dsTick = 1'b1;
    @(posedge clk); @(negedge clk);
    dsTick = 1'b0;
    wasAdj = mAdj; hit = mAdj && (mCnt == 1);
    expFs = 0; expAdj = 0;
    if (hit) begin np = 0; mAdj = 0; end
    else begin
      if (mAdj) mCnt--;
      np = (mPos == 192) ? 0 : mPos + 1;
    end
    if (np == 0) begin
      expFs = !wasAdj || hit; expAdj = hit;
      expByte = mMem[mWr][0]; mRd = mWr;
    end else if (np % 8 == 0 && np <= 184) expByte = mMem[mRd][np / 8];
    mPos = np;
    sinceMark++;
    chk(frameStart == expFs, wasAdj ? "R9 R6" : "R2", int'(frameStart), int'(expFs));
    chk(adjDone == expAdj, "R10", int'(adjDone), int'(expAdj));
    chk(int'(txByte) == expByte, "R3 R4 R5", int'(txByte), expByte);
    if (frameStart && firstFs < 0) firstFs = sinceMark;
    if (adjDone) adjCnt++;
  endtask

  task automatic sysWrite(int ch, int d);
    sysWrEn = 1'b1; sysChan = 5'(ch); sysData = 8'(d);
    @(posedge clk); @(negedge clk);
    sysWrEn = 1'b0;
    if (ch >= 1 && ch <= 24) begin
      if (ch == 1) mWr ^= 1;
      mMem[mWr][ch-1] = d & 255;
      if (ch == 1 && mArm) begin mAdj = 1; mCnt = mL; mArm = 0; end
    end
  endtask

  task automatic regWrite(int d);
    regWrEn = 1'b1; regData = 8'(d);
    @(posedge clk); @(negedge clk);
    regWrEn = 1'b0;
    if (d % 193 != 0) begin mArm = 1; mL = d % 193; mAdj = 0; end
  endtask

  task automatic writeFrame();
    frameNo++;
    for (int c = 1; c <= 24; c++) sysWrite(c, (frameNo * 37 + c * 11) & 255);
  endtask

  task automatic runCase(int d, int expL, int pre, bit doReg);
    int expFirst, adj0;
    repeat (pre) doTick();
    if (doReg) regWrite(d);
    repeat (3) doTick();
    expFirst = (expL != 0) ? expL : 193 - mPos;
    firstFs = -1; sinceMark = 0; adj0 = adjCnt;
    writeFrame();
    repeat (400) doTick();
    if (expL != 0) chk(firstFs == expFirst, "R6 R9", firstFs, expFirst);
    else chk(firstFs == expFirst, doReg ? "R8" : "R7", firstFs, expFirst);
    chk(adjCnt - adj0 == (expL != 0 ? 1 : 0), "R10", adjCnt - adj0, expL != 0 ? 1 : 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int s = 0; s < 24; s++) mMem[b][s] = 0;
    repeat (3) @(negedge clk);
    chk(frameStart == 1'b0, "R1", int'(frameStart), 0);
    chk(adjDone == 1'b0, "R1", int'(adjDone), 0);
    chk(txByte == 8'd0, "R1", int'(txByte), 0);
    rstN = 1'b1;
    @(negedge clk);
    firstFs = -1; sinceMark = 0;
    repeat (193) doTick();
    chk(firstFs == 193, "R1", firstFs, 193);
    writeFrame();
    sysWrite(0, 8'hA5); sysWrite(25, 8'h5A); sysWrite(31, 8'hFF);
    repeat (386) doTick();
    repeat (50) doTick();
    writeFrame();
    sysWrite(0, 8'h11);
    repeat (400) doTick();
    runCase(1, 1, 10, 1);
    runCase(2, 2, 77, 1);
    runCase(5, 5, 150, 1);
    runCase(100, 100, 20, 1);
    runCase(192, 192, 30, 1);
    runCase(200, 7, 61, 1);
    runCase(255, 62, 99, 1);
    runCase(0, 0, 40, 1);
    runCase(193, 0, 12, 1);
    runCase(17, 17, 5, 1);
    runCase(0, 0, 33, 0);
    regWrite(50);
    runCase(20, 20, 8, 1);
    regWrite(30);
    runCase(0, 30, 14, 1);
    regWrite(45);
    runCase(193, 45, 3, 1);
    runCase(0, 0, 90, 0);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end
endmodule